// File: doc/BRIEF.md
# Multi-Site Thermal Scan Controller

This block is the digital control side of an on-chip temperature monitor with up to sixteen sensing sites. Software reaches it through a 32-bit memory-mapped register port. It sets a run bit, picks which sites take part and chooses the pause between scan passes. It also stores calibration, range, adjustment and auxiliary mode words that the analog front end uses.

While running, a scan sequencer strobes the enabled sites one per clock in ascending order. It takes the raw reading and in-range flag that the abstract sensor port returns for the strobed site, and latches them into that site's read-only result register. After the highest enabled site it pauses for a programmable time before the next pass. Two layouts of the site mask exist, chosen by a build-time revision parameter. Revision 1 keeps a bit-reversed mask in the low half of the mode word. Revision 2 keeps a separate site register with a plain bit order and returns a wider result that carries a half-degree flag.

Top module: `thermal_scan_ctrl`

## Requirements
- R1: After reset the mode word reads 0, the interval register reads 0x0000000F, the revision-2 site register reads 0, every result register reads 0 and `sens_stb` stays low.
- R2: Offset 0xBF8 reads the revision number (1 or 2) in bits 15:8 with all other bits zero; writes to it change nothing.
- R3: Bit 31 of the mode word (offset 0x000) is the run bit. While it is clear `sens_stb` is low. In the cycle after a write that sets it, scanning starts at the lowest enabled site.
- R4: Site n is enabled by mode bit (15-n) in revision 1, or by bit n of the site register at offset 0x008 in revision 2. The mode word reads back exactly as written, including its filter bits.
- R5: While running, each cycle of a pass strobes one enabled site (`sens_stb`=1, `sens_site`=n) in ascending order. Disabled sites cost no cycles.
- R6: After the strobe of the highest enabled site, `sens_stb` stays low for (I+1)·PRESCALE cycles, then the pass restarts at the lowest enabled site. I is bits 3:0 of the interval register, at offset 0x008 in revision 1 and 0x00C in revision 2. A pass with no enabled site spends one cycle before that pause.
- R7: A strobe with `sens_ok`=1 makes the result register of that site (offset 0x100+16·n) read, from the next cycle on, bit 31 = 1, bits 30:10 = 0, and a temperature field. The field is `sens_raw`[7:0] in revision 1. In revision 2 it is `sens_raw`[9:0], with bit 9 as the half-degree flag.
- R8: A strobe with `sens_ok`=0 clears that site's bit 31 and keeps its previous temperature field.
- R9: A write that clears the run bit stops the strobes in the next cycle and clears every result bit 31 one cycle later. Temperature fields are kept.
- R10: Writes to result registers have no effect.
- R11: These registers read back the full 32-bit value last written and reset to 0: interrupt enable 0x020, temperature configuration 0x080, sensor configuration 0x084, sixteen range words at 0xF10+4·n, three auxiliary mode words at 0xF00/0xF04/0xF08, and sixteen adjustment words at 0x304+16·n.
- R12: A write to 0x084 raises `cal_we` for exactly the next cycle. `cal_sens_cfg` then carries the written value and `cal_temp_cfg` the value held at 0x080 when the write happened.
- R13: Unmapped or misaligned offsets read 0, and writes to them change no register. This includes 0x00C in revision 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sens_stb | output | 1 | Sample strobe for the site on `sens_site` |
| sens_site | output | 4 | Site being sampled |
| sens_raw | input | 10 | Raw reading of the strobed site |
| sens_ok | input | 1 | Reading of the strobed site is in range |
| cal_we | output | 1 | One-cycle calibration pair write |
| cal_temp_cfg | output | 32 | Temperature configuration word of the pair |
| cal_sens_cfg | output | 32 | Sensor configuration word of the pair |

## Verification
The risky coincidences are a sample landing in the same cycle as a register write. One case is a write that changes the mask, the interval or the run bit while a pass is in progress. The other is a result read in the very cycle its site is strobed. The bench writes masks, intervals and the run bit at arbitrary points of running passes, and sweeps result reads continuously during scanning. A behavioural model steps both revisions every clock and compares the strobe, the site number, the read data and the calibration port cycle by cycle, so a write taking effect one cycle early or late shows up as a miscompare.

// File: rtl/thermal_pkg.sv
`timescale 1ns/1ps
package thermal_pkg;
  localparam int NRANGE  = 16;
  localparam int NADJ    = 16;
  localparam int NEMR    = 3;
  localparam int IVL_RST = 15;

  localparam logic [11:0] A_MODE  = 12'h000;
  localparam logic [11:0] A_SITE  = 12'h008;
  localparam logic [11:0] A_IVL1  = 12'h008;
  localparam logic [11:0] A_IVL2  = 12'h00C;
  localparam logic [11:0] A_IER   = 12'h020;
  localparam logic [11:0] A_TCFG  = 12'h080;
  localparam logic [11:0] A_SCFG  = 12'h084;
  localparam logic [11:0] A_RES   = 12'h100;
  localparam logic [11:0] A_ADJ   = 12'h304;
  localparam logic [11:0] A_REVID = 12'hBF8;
  localparam logic [11:0] A_EMR   = 12'hF00;
  localparam logic [11:0] A_RNG   = 12'hF10;

  typedef enum logic {SC_SCAN, SC_WAIT} scan_st_e;
endpackage

// File: rtl/thermal_regfile.sv
`timescale 1ns/1ps
module thermal_regfile
  import thermal_pkg::*;
#(
  parameter int REV    = 2,
  parameter int NSITE  = 16,
  parameter int RAW_W  = 10,
  parameter int TW     = 10,
  parameter int IVL_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [11:0]            bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NSITE-1:0]       res_valid,
  input  logic [NSITE*RAW_W-1:0] res_temp,
  output logic                   mode_en,
  output logic [NSITE-1:0]       site_mask,
  output logic [IVL_W-1:0]       ivl,
  output logic                   cal_we,
  output logic [31:0]            cal_temp_cfg,
  output logic [31:0]            cal_sens_cfg
);
  localparam logic [11:0]      A_IVL = (REV == 1) ? A_IVL1 : A_IVL2;
  localparam logic [RAW_W-1:0] TMASK = RAW_W'((1 << TW) - 1);

  logic [31:0] mode_q, site_q, ivl_q, ier_q, tcfg_q, scfg_q, cal_t_q, cal_s_q;
  logic [31:0] rng_q [NRANGE];
  logic [31:0] adj_q [NADJ];
  logic [31:0] emr_q [NEMR];
  logic        cal_we_q;

  logic        hit_mode, hit_site, hit_ivl, hit_ier, hit_tcfg, hit_scfg, hit_rev;
  logic        hit_rng, hit_adj, hit_emr, hit_res;
  logic [11:0] rng_off, adj_off, emr_off, res_off;
  logic [3:0]  rng_idx, adj_idx, res_idx;
  logic [1:0]  emr_idx;

  // address decode
  always_comb begin
    hit_mode = (bus_addr == A_MODE);
    hit_site = (REV == 2) && (bus_addr == A_SITE);
    hit_ivl  = (bus_addr == A_IVL);
    hit_ier  = (bus_addr == A_IER);
    hit_tcfg = (bus_addr == A_TCFG);
    hit_scfg = (bus_addr == A_SCFG);
    hit_rev  = (bus_addr == A_REVID);
    rng_off  = bus_addr - A_RNG;
    adj_off  = bus_addr - A_ADJ;
    emr_off  = bus_addr - A_EMR;
    res_off  = bus_addr - A_RES;
    hit_rng  = (bus_addr >= A_RNG) && (rng_off < 12'(4*NRANGE)) && (bus_addr[1:0] == 2'b00);
    hit_adj  = (bus_addr >= A_ADJ) && (adj_off < 12'(16*NADJ)) && (adj_off[3:0] == 4'h0);
    hit_emr  = (bus_addr >= A_EMR) && (emr_off < 12'(4*NEMR)) && (bus_addr[1:0] == 2'b00);
    hit_res  = (bus_addr >= A_RES) && (res_off < 12'(16*NSITE)) && (res_off[3:0] == 4'h0);
    rng_idx  = rng_off[5:2];
    adj_idx  = adj_off[7:4];
    emr_idx  = emr_off[3:2];
    res_idx  = res_off[7:4];
  end

  // storage with explicit write enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      site_q   <= '0;
      ivl_q    <= 32'(IVL_RST);
      ier_q    <= '0;
      tcfg_q   <= '0;
      scfg_q   <= '0;
      cal_t_q  <= '0;
      cal_s_q  <= '0;
      cal_we_q <= 1'b0;
      for (int k = 0; k < NRANGE; k++) rng_q[k] <= '0;
      for (int k = 0; k < NADJ; k++)   adj_q[k] <= '0;
      for (int k = 0; k < NEMR; k++)   emr_q[k] <= '0;
    end else begin
      cal_we_q <= bus_we && hit_scfg;
      if (bus_we && hit_mode) mode_q <= bus_wdata;
      if (bus_we && hit_site) site_q <= bus_wdata;
      if (bus_we && hit_ivl)  ivl_q  <= bus_wdata;
      if (bus_we && hit_ier)  ier_q  <= bus_wdata;
      if (bus_we && hit_tcfg) tcfg_q <= bus_wdata;
      if (bus_we && hit_scfg) begin
        scfg_q  <= bus_wdata;
        cal_t_q <= tcfg_q;
        cal_s_q <= bus_wdata;
      end
      if (bus_we && hit_rng) rng_q[rng_idx] <= bus_wdata;
      if (bus_we && hit_adj) adj_q[adj_idx] <= bus_wdata;
      if (bus_we && hit_emr) emr_q[emr_idx] <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_mode)      bus_rdata = mode_q;
    else if (hit_site) bus_rdata = site_q;
    else if (hit_ivl)  bus_rdata = ivl_q;
    else if (hit_ier)  bus_rdata = ier_q;
    else if (hit_tcfg) bus_rdata = tcfg_q;
    else if (hit_scfg) bus_rdata = scfg_q;
    else if (hit_rev)  bus_rdata = {16'h0000, 8'(REV), 8'h00};
    else if (hit_rng)  bus_rdata = rng_q[rng_idx];
    else if (hit_adj)  bus_rdata = adj_q[adj_idx];
    else if (hit_emr)  bus_rdata = emr_q[emr_idx];
    else if (hit_res) begin
      bus_rdata     = 32'(res_temp[res_idx*RAW_W +: RAW_W] & TMASK);
      bus_rdata[31] = res_valid[res_idx];
    end
  end

  // site mask layout chosen by revision
  for (genvar n = 0; n < NSITE; n++) begin : g_mask
    if (REV == 1) begin : g_rev1
      assign site_mask[n] = mode_q[15-n];
    end else begin : g_rev2
      assign site_mask[n] = site_q[n];
    end
  end

  assign mode_en      = mode_q[31];
  assign ivl          = ivl_q[IVL_W-1:0];
  assign cal_we       = cal_we_q;
  assign cal_temp_cfg = cal_t_q;
  assign cal_sens_cfg = cal_s_q;
endmodule

// File: rtl/thermal_scanner.sv
`timescale 1ns/1ps
module thermal_scanner
  import thermal_pkg::*;
#(
  parameter int NSITE    = 16,
  parameter int IVL_W    = 4,
  parameter int PRESCALE = 8,
  parameter int SITE_W   = $clog2(NSITE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic [NSITE-1:0]  site_mask,
  input  logic [IVL_W-1:0]  ivl,
  output logic              sens_stb,
  output logic [SITE_W-1:0] sens_site
);
  localparam int PTR_W = SITE_W + 1;
  localparam int CNT_W = $clog2((1 << IVL_W) * PRESCALE);

  scan_st_e          st_q, st_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, nxt_ptr;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_load;
  logic              found, more;
  logic [SITE_W-1:0] pick;

  // first enabled site at or above the pointer, and whether another follows
  always_comb begin
    found   = 1'b0;
    more    = 1'b0;
    pick    = '0;
    nxt_ptr = '0;
    for (int k = 0; k < NSITE; k++) begin
      if (site_mask[k] && (k >= int'(ptr_q))) begin
        if (!found) begin
          found   = 1'b1;
          pick    = SITE_W'(k);
          nxt_ptr = PTR_W'(k + 1);
        end else begin
          more = 1'b1;
        end
      end
    end
  end

  assign cnt_load = CNT_W'((int'(ivl) + 1) * PRESCALE - 1);

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    cnt_d = cnt_q;
    if (!mode_en) begin
      st_d  = SC_SCAN;
      ptr_d = '0;
      cnt_d = '0;
    end else begin
      case (st_q)
        SC_SCAN: begin
          if (found) ptr_d = nxt_ptr;
          if (!found || !more) begin
            st_d  = SC_WAIT;
            cnt_d = cnt_load;
          end
        end
        SC_WAIT: begin
          if (cnt_q == '0) begin
            st_d  = SC_SCAN;
            ptr_d = '0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: st_d = SC_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_SCAN;
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sens_stb  = mode_en && (st_q == SC_SCAN) && found;
  assign sens_site = pick;
endmodule

// File: rtl/thermal_results.sv
`timescale 1ns/1ps
module thermal_results #(
  parameter int NSITE  = 16,
  parameter int RAW_W  = 10,
  parameter int SITE_W = $clog2(NSITE)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_en,
  input  logic                   samp_stb,
  input  logic [SITE_W-1:0]      samp_site,
  input  logic [RAW_W-1:0]       samp_raw,
  input  logic                   samp_ok,
  output logic [NSITE-1:0]       res_valid,
  output logic [NSITE*RAW_W-1:0] res_temp
);
  for (genvar n = 0; n < NSITE; n++) begin : g_site
    logic             hit, val_q, val_d;
    logic [RAW_W-1:0] tmp_q, tmp_d;

    always_comb begin
      hit   = samp_stb && (samp_site == SITE_W'(n));
      val_d = val_q;
      tmp_d = tmp_q;
      if (!mode_en) begin
        val_d = 1'b0;
      end else if (hit) begin
        val_d = samp_ok;
        if (samp_ok) tmp_d = samp_raw;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= 1'b0;
        tmp_q <= '0;
      end else begin
        val_q <= val_d;
        tmp_q <= tmp_d;
      end
    end

    assign res_valid[n]                 = val_q;
    assign res_temp[n*RAW_W +: RAW_W]   = tmp_q;
  end
endmodule

// File: rtl/thermal_scan_ctrl.sv
`timescale 1ns/1ps
module thermal_scan_ctrl #(
  parameter int REV      = 2,
  parameter int NSITE    = 16,
  parameter int RAW_W    = 10,
  parameter int IVL_W    = 4,
  parameter int PRESCALE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sens_stb,
  output logic [3:0]  sens_site,
  input  logic [9:0]  sens_raw,
  input  logic        sens_ok,
  output logic        cal_we,
  output logic [31:0] cal_temp_cfg,
  output logic [31:0] cal_sens_cfg
);
  localparam int SITE_W = $clog2(NSITE);
  localparam int TW     = (REV == 1) ? 8 : 10;

  logic                   mode_en;
  logic [NSITE-1:0]       site_mask;
  logic [IVL_W-1:0]       ivl;
  logic [NSITE-1:0]       res_valid;
  logic [NSITE*RAW_W-1:0] res_temp;
  logic [SITE_W-1:0]      site_idx;

  thermal_regfile #(
    .REV(REV), .NSITE(NSITE), .RAW_W(RAW_W), .TW(TW), .IVL_W(IVL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .res_valid(res_valid), .res_temp(res_temp),
    .mode_en(mode_en), .site_mask(site_mask), .ivl(ivl),
    .cal_we(cal_we), .cal_temp_cfg(cal_temp_cfg), .cal_sens_cfg(cal_sens_cfg)
  );

  thermal_scanner #(
    .NSITE(NSITE), .IVL_W(IVL_W), .PRESCALE(PRESCALE), .SITE_W(SITE_W)
  ) u_scan (
    .clk(clk), .rst_n(rst_n),
    .mode_en(mode_en), .site_mask(site_mask), .ivl(ivl),
    .sens_stb(sens_stb), .sens_site(site_idx)
  );

  thermal_results #(
    .NSITE(NSITE), .RAW_W(RAW_W), .SITE_W(SITE_W)
  ) u_res (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
    .samp_stb(sens_stb), .samp_site(site_idx),
    .samp_raw(sens_raw[RAW_W-1:0]), .samp_ok(sens_ok),
    .res_valid(res_valid), .res_temp(res_temp)
  );

  assign sens_site = 4'(site_idx);
endmodule

// File: rtl/thermal_scan_chk.sv
`timescale 1ns/1ps
module thermal_scan_chk #(
  parameter int NSITE  = 16,
  parameter int SITE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en,
  input logic [NSITE-1:0]  site_mask,
  input logic              sens_stb,
  input logic [SITE_W-1:0] sens_site,
  input logic              sens_ok,
  input logic [NSITE-1:0]  res_valid,
  input logic              bus_we,
  input logic [11:0]       bus_addr,
  input logic              cal_we
);
  assert_stb_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !sens_stb);

  assert_site_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sens_stb |-> site_mask[sens_site]);

  assert_latch_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_stb && sens_ok) |=> res_valid[$past(sens_site)]);

  assert_oor_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_stb && !sens_ok) |=> !res_valid[$past(sens_site)]);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> (res_valid == '0));

  assert_cal_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |-> $past(bus_we && (bus_addr == 12'h084)));
endmodule

bind thermal_scan_ctrl thermal_scan_chk #(.NSITE(NSITE), .SITE_W(SITE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .site_mask(site_mask),
  .sens_stb(sens_stb), .sens_site(site_idx), .sens_ok(sens_ok),
  .res_valid(res_valid), .bus_we(bus_we), .bus_addr(bus_addr), .cal_we(cal_we)
);

// File: tb/sim_thermal_scan_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_scan_ctrl;
  localparam int PS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        we   [2];
  logic [11:0] addr [2];
  logic [31:0] wd   [2];
  logic [31:0] rdt  [2];
  logic        stb  [2];
  logic [3:0]  site [2];
  logic [9:0]  raw  [2];
  logic        okv  [2];
  logic        cwe  [2];
  logic [31:0] ct   [2];
  logic [31:0] cs   [2];

  int  raw_t [16];
  bit  ok_t  [16];

  int    vectors = 0;
  int    miscompares = 0;
  bit    checking = 1'b0;
  string cur_req = "R1";

  thermal_scan_ctrl #(.REV(2), .PRESCALE(PS)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(we[0]), .bus_addr(addr[0]), .bus_wdata(wd[0]),
    .bus_rdata(rdt[0]), .sens_stb(stb[0]), .sens_site(site[0]), .sens_raw(raw[0]),
    .sens_ok(okv[0]), .cal_we(cwe[0]), .cal_temp_cfg(ct[0]), .cal_sens_cfg(cs[0]));

  thermal_scan_ctrl #(.REV(1), .PRESCALE(PS)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_we(we[1]), .bus_addr(addr[1]), .bus_wdata(wd[1]),
    .bus_rdata(rdt[1]), .sens_stb(stb[1]), .sens_site(site[1]), .sens_raw(raw[1]),
    .sens_ok(okv[1]), .cal_we(cwe[1]), .cal_temp_cfg(ct[1]), .cal_sens_cfg(cs[1]));

  // abstract sensors: answer for whichever site is strobed
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      raw[i] = 10'(raw_t[site[i]]);
      okv[i] = ok_t[site[i]];
    end
  end

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_mode [2], m_site [2], m_ivl [2], m_ier [2], m_tcfg [2], m_scfg [2];
  bit [31:0] m_rng [2][16], m_adj [2][16], m_emr [2][3];
  bit        m_val [2][16];
  int        m_tmp [2][16];
  bit        m_wait [2];
  int        m_ptr [2], m_cnt [2];
  bit        m_calp [2];
  bit [31:0] m_calt [2], m_cals [2];

  function automatic int rev_of(input int i);
    return (i == 0) ? 2 : 1;
  endfunction

  function automatic bit enabled(input int i, input int n);
    if (rev_of(i) == 1) return m_mode[i][15-n];
    return m_site[i][n];
  endfunction

  // returns first enabled site >= ptr or -1; more tells whether another follows
  function automatic int find(input int i, output bit more);
    int p = -1;
    more = 1'b0;
    for (int n = m_ptr[i]; n < 16; n++)
      if (enabled(i, n)) begin
        if (p < 0) p = n; else more = 1'b1;
      end
    return p;
  endfunction

  function automatic bit exp_stb(input int i, output int s);
    bit mo;
    s = find(i, mo);
    return m_mode[i][31] && !m_wait[i] && (s >= 0);
  endfunction

  function automatic bit [31:0] exp_rd(input int i, input int a);
    int ia = (rev_of(i) == 1) ? 'h008 : 'h00C;
    if (a == 'h000) return m_mode[i];
    if (rev_of(i) == 2 && a == 'h008) return m_site[i];
    if (a == ia) return m_ivl[i];
    if (a == 'h020) return m_ier[i];
    if (a == 'h080) return m_tcfg[i];
    if (a == 'h084) return m_scfg[i];
    if (a == 'hBF8) return 32'(rev_of(i) << 8);
    if (a >= 'hF10 && a <= 'hF4C && a % 4 == 0) return m_rng[i][(a - 'hF10) / 4];
    if (a >= 'h304 && a <= 'h3F4 && a % 16 == 4) return m_adj[i][(a - 'h304) / 16];
    if (a == 'hF00 || a == 'hF04 || a == 'hF08) return m_emr[i][(a - 'hF00) / 4];
    if (a >= 'h100 && a <= 'h1F0 && a % 16 == 0) begin
      int n = (a - 'h100) / 16;
      int t = m_tmp[i][n] & ((rev_of(i) == 1) ? 'hFF : 'h3FF);
      return {m_val[i][n], 31'(t)};
    end
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_mode[i] = 0; m_site[i] = 0; m_ivl[i] = 15; m_ier[i] = 0; m_tcfg[i] = 0; m_scfg[i] = 0;
      for (int n = 0; n < 16; n++) begin
        m_rng[i][n] = 0; m_adj[i][n] = 0; m_val[i][n] = 0; m_tmp[i][n] = 0;
      end
      for (int n = 0; n < 3; n++) m_emr[i][n] = 0;
      m_wait[i] = 0; m_ptr[i] = 0; m_cnt[i] = 0;
      m_calp[i] = 0; m_calt[i] = 0; m_cals[i] = 0;
    end
  endtask

  task automatic model_step(input int i);
    bit mo;
    int p;
    int a;
    int ia = (rev_of(i) == 1) ? 'h008 : 'h00C;
    if (!m_mode[i][31]) begin
      for (int n = 0; n < 16; n++) m_val[i][n] = 0;
      m_ptr[i] = 0; m_wait[i] = 0;
    end else if (!m_wait[i]) begin
      p = find(i, mo);
      if (p >= 0) begin
        m_val[i][p] = ok_t[p];
        if (ok_t[p]) m_tmp[i][p] = raw_t[p];
        m_ptr[i] = p + 1;
      end
      if (p < 0 || !mo) begin
        m_wait[i] = 1;
        m_cnt[i] = (int'(m_ivl[i][3:0]) + 1) * PS - 1;
      end
    end else if (m_cnt[i] == 0) begin
      m_wait[i] = 0; m_ptr[i] = 0;
    end else begin
      m_cnt[i]--;
    end
    m_calp[i] = 0;
    if (we[i]) begin
      a = int'(addr[i]);
      if (a == 'h084) begin m_calp[i] = 1; m_calt[i] = m_tcfg[i]; m_cals[i] = wd[i]; end
      if (a == 'h000) m_mode[i] = wd[i];
      else if (rev_of(i) == 2 && a == 'h008) m_site[i] = wd[i];
      else if (a == ia) m_ivl[i] = wd[i];
      else if (a == 'h020) m_ier[i] = wd[i];
      else if (a == 'h080) m_tcfg[i] = wd[i];
      else if (a == 'h084) m_scfg[i] = wd[i];
      else if (a >= 'hF10 && a <= 'hF4C && a % 4 == 0) m_rng[i][(a - 'hF10) / 4] = wd[i];
      else if (a >= 'h304 && a <= 'h3F4 && a % 16 == 4) m_adj[i][(a - 'h304) / 16] = wd[i];
      else if (a == 'hF00 || a == 'hF04 || a == 'hF08) m_emr[i][(a - 'hF00) / 4] = wd[i];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      model_step(0);
      model_step(1);
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic cmp(input string what, input int i, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s u%0d %s: actual %h expected %h at %0t", cur_req, i, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (checking && rst_n) begin
      for (int i = 0; i < 2; i++) begin
        int  s;
        bit  es;
        es = exp_stb(i, s);
        cmp("sens_stb", i, int'(stb[i]), int'(es));
        if (es) cmp("sens_site", i, int'(site[i]), s);
        cmp("bus_rdata", i, int'(rdt[i]), int'(exp_rd(i, int'(addr[i]))));
        cmp("cal_we", i, int'(cwe[i]), int'(m_calp[i]));
        if (m_calp[i]) begin
          cmp("cal_temp_cfg", i, int'(ct[i]), int'(m_calt[i]));
          cmp("cal_sens_cfg", i, int'(cs[i]), int'(m_cals[i]));
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int i, input int a, input int d);
    @(negedge clk);
    we[i] = 1'b1; addr[i] = 12'(a); wd[i] = 32'(d);
    @(negedge clk);
    we[i] = 1'b0;
  endtask

  // directed read with a hand-computed expectation
  task automatic rdchk(input int i, input int a, input int exp, input string req);
    @(negedge clk);
    addr[i] = 12'(a);
    #5;
    vectors++;
    if (rdt[i] != 32'(exp)) begin
      miscompares++;
      $display("FAIL %s u%0d read %h: actual %h expected %h", req, i, a, rdt[i], exp);
    end
  endtask

  task automatic sweep(input int i);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      addr[i] = 12'('h100 + 16 * n);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin we[i] = 0; addr[i] = 0; wd[i] = 0; end
    for (int n = 0; n < 16; n++) begin raw_t[n] = (100 + 37 * n) & 'h3FF; ok_t[n] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checking = 1'b1;

    // R1 reset state
    cur_req = "R1";
    rdchk(0, 'h000, 0, "R1"); rdchk(0, 'h008, 0, "R1"); rdchk(0, 'h00C, 15, "R1");
    rdchk(1, 'h008, 15, "R1"); rdchk(0, 'h100, 0, "R1"); rdchk(1, 'h1F0, 0, "R1");

    // R2 revision register
    cur_req = "R2";
    rdchk(0, 'hBF8, 'h200, "R2"); rdchk(1, 'hBF8, 'h100, "R2");
    wr(0, 'hBF8, -1); wr(1, 'hBF8, 0);
    rdchk(0, 'hBF8, 'h200, "R2"); rdchk(1, 'hBF8, 'h100, "R2");

    // R11 plain storage
    cur_req = "R11";
    foreach (raw_t[k]) begin
      int al [8] = '{'h020, 'h080, 'hF10, 'hF4C, 'hF00, 'hF08, 'h304, 'h3F4};
      if (k < 8) begin
        wr(k % 2, al[k], (al[k] * 32'h01010101) ^ 32'hA5A50000);
        rdchk(k % 2, al[k], (al[k] * 32'h01010101) ^ 32'hA5A50000, "R11");
      end
    end

    // R12 calibration pair forwarding
    cur_req = "R12";
    wr(0, 'h080, 'h1234_5678);
    wr(0, 'h084, 'h0000_BEEF);
    #5;
    vectors++;
    if (cwe[0] !== 1'b1 || cs[0] !== 32'hBEEF || ct[0] !== 32'h1234_5678) begin
      miscompares++;
      $display("FAIL R12 cal pair: actual we=%b t=%h s=%h expected we=1 t=12345678 s=0000beef",
               cwe[0], ct[0], cs[0]);
    end
    @(negedge clk); #5;
    vectors++;
    if (cwe[0] !== 1'b0) begin
      miscompares++;
      $display("FAIL R12 strobe length: actual %b expected 0", cwe[0]);
    end
    wr(1, 'h084, 'h55);

    // R13 unmapped offsets
    cur_req = "R13";
    wr(1, 'h00C, 5); wr(0, 'h010, 7); wr(0, 'h002, 9); wr(0, 'h0FC, 1); wr(1, 'h306, 3);
    rdchk(1, 'h00C, 0, "R13"); rdchk(0, 'h010, 0, "R13"); rdchk(0, 'h002, 0, "R13");
    rdchk(1, 'h008, 15, "R13"); rdchk(0, 'h000, 0, "R13"); rdchk(1, 'h306, 0, "R13");

    // R4 R5 R6 masks, ordering and pass pause
    cur_req = "R4";
    wr(0, 'h00C, 1); wr(0, 'h008, 'h8025); wr(1, 'h008, 1);
    cur_req = "R3";
    wr(0, 'h000, 32'h8300_0000);
    wr(1, 'h000, 32'h8C00_5002);
    rdchk(1, 'h000, 32'h8C00_5002, "R4");
    cur_req = "R5";
    idle(60); sweep(0); sweep(1);

    // R7 new readings
    cur_req = "R7";
    for (int n = 0; n < 16; n++) raw_t[n] = (512 + 19 * n) & 'h3FF;
    idle(50); sweep(0); sweep(1);

    // R8 out-of-range readings
    cur_req = "R8";
    ok_t[5] = 0; ok_t[3] = 0; ok_t[14] = 0;
    idle(60); sweep(0); sweep(1);
    ok_t[5] = 1; ok_t[3] = 1; ok_t[14] = 1;
    idle(40);

    // R6 interval changes and empty mask
    cur_req = "R6";
    wr(0, 'h00C, 0); wr(1, 'h008, 3);
    idle(80);
    wr(0, 'h008, 0); idle(40);
    wr(0, 'h008, 'hFFFF); wr(1, 'h000, 32'h8000_FFFF);
    idle(80); sweep(0); sweep(1);

    // R10 result registers are read-only
    cur_req = "R10";
    wr(0, 'h100, 0); wr(0, 'h150, 'h3FF); wr(1, 'h1E0, 0);
    sweep(0); sweep(1);

    // R9 stop clears valid flags
    cur_req = "R9";
    wr(0, 'h000, 0); wr(1, 'h000, 32'h0C00_5002);
    idle(3);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); addr[i] = 12'h120; #5;
      vectors++;
      if (rdt[i][31] !== 1'b0 || stb[i] !== 1'b0) begin
        miscompares++;
        $display("FAIL R9 u%0d: actual valid=%b stb=%b expected 0 0", i, rdt[i][31], stb[i]);
      end
    end
    sweep(0); sweep(1);

    // R3 restart from lowest enabled site
    cur_req = "R3";
    wr(1, 'h000, 32'h8C00_5002); wr(0, 'h008, 'h0410); wr(0, 'h000, 32'h8000_0000);
    idle(60); sweep(0); sweep(1);

    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule